// File: doc/BRIEF.md
# Gated Phase Interval Counter

This block turns a phase-comparator window into a number. The window is an asynchronous level that is high for the interval between a reference pulse and the divided oscillator edge. A fast count clock (100 MHz, so each count is 10 ns) runs all the time. While the window is high the counter advances. The window never touches the clock. It passes through a shift-register synchronizer, and the synchronizer's output drives the counter's enable, so every flip-flop sees the clock directly.

A synchronous one-second tick ends each measurement. On the tick edge the running count goes into an output register and a valid strobe is raised for one cycle. On that same edge the counter starts again from zero. A window is expected to last at most 1.6 us (0 to 160 counts), and about 64 counts at the nominal operating point.

The counter is 8 bits wide. If it is asked to go past 255 it holds at 255 and sets an overflow flag. That flag is reported with the captured count and is cleared for the next interval.

Top module: `phase_interval_counter`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `capCount` is 0 and `capValid` and `capOverflow` are low. A reset in the middle of a count discards that count.
- R2: Over one interval, the captured count equals the number of rising clock edges at which `windowAsync` was sampled high. The synchronizer delays the enable by the same number of cycles on the rising edge and on the falling edge of the window, so no count is gained or lost.
- R3: When `tick` is sampled high, the count is written to `capCount` on that same edge and `capValid` is high for exactly the following cycle. `capValid` is never high unless `tick` was high one cycle before.
- R4: On the tick edge the counter is cleared, and the increment for that same edge is kept in the captured value. A window that is still open across a tick is therefore split between two captures with no count lost.
- R5: The count saturates at 255 (all ones in 8 bits). A window exactly 255 cycles long gives 255 with no overflow.
- R6: If an increment is requested while the count is already 255, `capOverflow` is reported high together with the capture, and `capCount` reads 255. The next interval starts with the flag clear.
- R7: `capCount` and `capOverflow` do not change except on a tick edge or a reset.
- R8: At a typical window of 64 cycles, and at the largest in-range window of 160 cycles, the captured value is exactly the window length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running count clock |
| rstN | input | 1 | Asynchronous reset, active low |
| windowAsync | input | 1 | Phase window from the comparator, asynchronous to `clk` |
| tick | input | 1 | One-second capture request, synchronous, one cycle wide |
| capCount | output | 8 | Count captured at the last tick |
| capOverflow | output | 1 | High if the captured interval tried to count past 255 |
| capValid | output | 1 | One-cycle strobe in the cycle after a capture |

## Verification
The assertions take `tick` to be a synchronous pulse. They make no assumption about when `windowAsync` changes relative to the clock, because their properties use only the synchronous ports and the captured outputs. The bench changes `windowAsync` and `tick` only on the falling clock edge, so each window has an exact number of sampled-high rising edges and the expected count is known without any metastability. Every window is followed by four idle cycles before the tick, except in the one test that deliberately places a tick inside an open window. This lets the two-stage enable drain completely before the capture.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;   // synchronized window
    logic capture;   // tick: latch and clear
  } picCtl_t;
endpackage

// File: rtl/pic_sync.sv
`timescale 1ns/1ps
module pic_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[LAST-1:0], asyncIn};
  end

  assign syncOut = chain[LAST];
endmodule

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    windowAsync,
  input  logic    tick,
  output picCtl_t ctl
);
  logic windowSync;

  pic_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (windowAsync),
    .syncOut (windowSync)
  );

  always_comb begin
    ctl.countEn = windowSync;
    ctl.capture = tick;
  end
endmodule

// File: rtl/pic_datapath.sv
`timescale 1ns/1ps
module pic_datapath
  import pic_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  picCtl_t          ctl,
  output logic [CNT_W-1:0] capCount,
  output logic             capOverflow,
  output logic             capValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] runCount;
  logic             runOvf;
  logic [CNT_W-1:0] nextCount;
  logic             nextOvf;
  logic             atMax;

  always_comb begin
    atMax     = (runCount == CNT_MAX);
    nextCount = (ctl.countEn && !atMax) ? runCount + 1'b1 : runCount;
    nextOvf   = runOvf | (ctl.countEn & atMax);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount    <= '0;
      runOvf      <= 1'b0;
      capCount    <= '0;
      capOverflow <= 1'b0;
      capValid    <= 1'b0;
    end else begin
      capValid <= ctl.capture;
      if (ctl.capture) begin
        capCount    <= nextCount;
        capOverflow <= nextOvf;
        runCount    <= '0;
        runOvf      <= 1'b0;
      end else begin
        runCount <= nextCount;
        runOvf   <= nextOvf;
      end
    end
  end
endmodule

// File: rtl/phase_interval_counter.sv
`timescale 1ns/1ps
module phase_interval_counter
  import pic_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             windowAsync,
  input  logic             tick,
  output logic [CNT_W-1:0] capCount,
  output logic             capOverflow,
  output logic             capValid
);
  picCtl_t ctl;

  pic_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .windowAsync (windowAsync),
    .tick        (tick),
    .ctl         (ctl)
  );

  pic_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .capCount    (capCount),
    .capOverflow (capOverflow),
    .capValid    (capValid)
  );
endmodule

// File: rtl/pic_checker.sv
`timescale 1ns/1ps
module pic_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [CNT_W-1:0] capCount,
  input logic             capOverflow,
  input logic             capValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (capCount == '0 && !capValid && !capOverflow)); // R1

  AST_TICK_GIVES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> capValid); // R3

  AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !capValid); // R3

  AST_OVF_AT_SATURATION: assert property (@(posedge clk) disable iff (!rstN)
    capOverflow |-> (capCount == CNT_MAX)); // R6

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(capCount)); // R7

  AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(capOverflow)); // R7
endmodule

bind phase_interval_counter pic_checker #(.CNT_W(CNT_W)) u_pic_checker (
  .clk         (clk),
  .rstN        (rstN),
  .tick        (tick),
  .capCount    (capCount),
  .capOverflow (capOverflow),
  .capValid    (capValid)
);

// File: tb/phase_interval_counter_bench.sv
`timescale 1ns/1ps
module phase_interval_counter_bench;
  localparam int CNT_W = 8;
  localparam int NVEC  = 9;
  // window length, expected count, expected overflow
  localparam int VEC_LEN [NVEC] = '{0, 1, 64, 256, 160, 300, 255, 0, 37};
  localparam int VEC_CNT [NVEC] = '{0, 1, 64, 255, 160, 255, 255, 0, 37};
  localparam int VEC_OVF [NVEC] = '{0, 0, 0,  1,   0,   1,   0,   0, 0};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             windowAsync = 1'b0;
  logic             tick = 1'b0;
  logic [CNT_W-1:0] capCount;
  logic             capOverflow;
  logic             capValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phase_interval_counter #(.CNT_W(CNT_W)) u_phase_interval_counter (
    .clk         (clk),
    .rstN        (rstN),
    .windowAsync (windowAsync),
    .tick        (tick),
    .capCount    (capCount),
    .capOverflow (capOverflow),
    .capValid    (capValid)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // window high for len rising edges, drain, then tick; returns after capture edge
  task automatic measure(input int len);
    windowAsync = (len > 0);
    repeat (len) @(negedge clk);
    windowAsync = 1'b0;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    int firstCap;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 count in reset", capCount, 0);
    check("R1 valid in reset", capValid, 0);
    check("R1 ovf in reset", capOverflow, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 count after release", capCount, 0);
    check("R1 valid after release", capValid, 0);

    // Vector table: R2, R5, R6, R8
    for (int i = 0; i < NVEC; i++) begin
      measure(VEC_LEN[i]);
      check("R3 valid after tick", capValid, 1);
      check("R2 R5 R8 captured count", capCount, VEC_CNT[i]);
      check("R6 overflow flag", capOverflow, VEC_OVF[i]);
      @(negedge clk);
      check("R3 valid one cycle", capValid, 0);
      repeat (5) @(negedge clk);
      check("R7 count held", capCount, VEC_CNT[i]);
      check("R7 ovf held", capOverflow, VEC_OVF[i]);
    end

    // R4: tick inside an open window, 20 edges total
    windowAsync = 1'b1;
    repeat (7) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    firstCap = int'(capCount);
    check("R4 split first part", firstCap, 6);
    repeat (12) @(negedge clk);
    windowAsync = 1'b0;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R4 split second part", capCount, 14);
    check("R4 split total", firstCap + int'(capCount), 20);

    // R1: reset mid-count discards the count
    windowAsync = 1'b1;
    repeat (30) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 count cleared by reset", capCount, 0);
    windowAsync = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R1 no leftover count", capCount, 0);
    check("R1 no leftover ovf", capOverflow, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule